// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator and Shared Open-Drain Output

This block decides when a calendar alarm fires and what a single shared open-drain output pin shows. Five alarm fields (seconds, minutes, hours, day of month, month) are held outside the block. Each is an 8-bit register whose top bit is an active-low enable: a field takes part in the comparison only when that bit is 0. The other bits hold a BCD value that is compared with the matching field of the current time. The comparison is evaluated only on a once-per-second strobe. When every enabled field is equal on that strobe, a sticky alarm flag is set. The flag stays set until the host reads the control register, which the block sees as a one-cycle read strobe.

The output pin can only pull low. A priority decode of three control bits selects what it shows. Calibration mode has the highest priority and shows a 512 Hz tone. Next, a wave-select setting shows one of four square-wave taps from an external divider. The active-low alarm comes after that. When none of these applies, the pin is released.

Top module: `rtc_alarm_out`

## Requirements
- R1: After reset, `alarm_flag` is 0.
- R2: A field whose alarm register has bit 7 = 0 must equal the current time field for a match. A field with bit 7 = 1 is left out of the comparison.
- R3: With bit 7 = 1 in all five alarm registers, every `sec_tick` sets `alarm_flag` in the cycle after the strobe.
- R4: Without `sec_tick`, `alarm_flag` never goes from 0 to 1, even when the enabled fields match.
- R5: Once set, `alarm_flag` stays at 1 until `ctrl_rd` is sampled high. In the cycle after that read it is 0, provided no new match arrives on the same edge.
- R6: When a qualifying match on `sec_tick` and `ctrl_rd` fall on the same edge, `alarm_flag` is 1 afterwards.
- R7: With `cal_mode` = 1, `pin_pull_low` equals the inverse of `freq_taps[1]` (the 512 Hz tap), whatever the other control bits are. The alarm flag keeps setting on matches in this mode.
- R8: With `cal_mode` = 0 and `alarm_sel` = 0, `pin_pull_low` equals the inverse of `freq_taps[wave_sel]`, whatever `alarm_en` is. The tap index is 0 = 1 Hz, 1 = 512 Hz, 2 = 4096 Hz, 3 = 32768 Hz.
- R9: With `cal_mode` = 0, `alarm_en` = 1 and `alarm_sel` = 1, `pin_pull_low` equals `alarm_flag`.
- R10: With `cal_mode` = 0, `alarm_en` = 0 and `alarm_sel` = 1, `pin_pull_low` is 0 (pin released).
- R11: Only the valid BCD width of each alarm field is compared: seconds and minutes use bits 6:0, hours and date use bits 5:0, and month uses bits 4:0. The other bits below bit 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second, that enables the comparison |
| ctrl_rd | input | 1 | One-cycle strobe marking a read of the control register |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| cur_mon | input | 5 | Current month, BCD |
| alm_sec | input | 8 | Seconds alarm: bit 7 is the active-low enable, bits 6:0 hold the value |
| alm_min | input | 8 | Minutes alarm: bit 7 is the active-low enable, bits 6:0 hold the value |
| alm_hour | input | 8 | Hours alarm: bit 7 is the active-low enable, bits 5:0 hold the value |
| alm_date | input | 8 | Date alarm: bit 7 is the active-low enable, bits 5:0 hold the value |
| alm_mon | input | 8 | Month alarm: bit 7 is the active-low enable, bits 4:0 hold the value |
| cal_mode | input | 1 | Calibration tone select (highest priority) |
| alarm_en | input | 1 | Lets the alarm drive the pin |
| alarm_sel | input | 1 | 1 = alarm or released, 0 = square wave |
| wave_sel | input | 2 | Square-wave tap index |
| freq_taps | input | 4 | Divider taps: 1 Hz, 512 Hz, 4096 Hz, 32768 Hz |
| alarm_flag | output | 1 | Sticky alarm flag |
| pin_pull_low | output | 1 | Open-drain enable: 1 pulls the pin low |

## Verification
The flag-setting match and the clearing read can land on the same clock edge. The bench provokes this with a directed case in which a fully enabled, exactly matching time arrives together with `ctrl_rd` while the flag is already set. Random cycles also assert tick and read together often. The set must win: the flag is checked as 1 one cycle later. A plain read with no tick that follows is checked to clear it. A second overlap is calibration mode and the alarm comparison running at once: the pin must follow the 512 Hz tap while the flag still sets.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int NUM_FIELDS = 5;
    localparam int REG_W      = 8;
    localparam int EN_BIT     = REG_W - 1;

    // Field order: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month
    function automatic int field_width(input int idx);
        case (idx)
            0, 1:    return 7;
            2, 3:    return 6;
            default: return 5;
        endcase
    endfunction

    typedef enum logic [1:0] {
        PIN_CAL   = 2'd0,
        PIN_WAVE  = 2'd1,
        PIN_ALARM = 2'd2,
        PIN_OFF   = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][REG_W-1:0] alarm_regs,
    input  logic [NUM_FIELDS-1:0][REG_W-1:0] time_vals,
    output logic                             match_all
);

    logic [NUM_FIELDS-1:0] field_hit;

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        localparam int W = field_width(gi);
        // Enable bit high means "don't care"; only the valid BCD width is compared
        assign field_hit[gi] = alarm_regs[gi][EN_BIT]
                             | (alarm_regs[gi][W-1:0] == time_vals[gi][W-1:0]);
    end

    assign match_all = &field_hit;

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_evt) begin
            st_d.flag = 1'b1;      // a fresh match outranks the clearing read
        end else if (clr_evt) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/rtc_alarm_pinmux.sv
module rtc_alarm_pinmux
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_TAPS = 4,
    parameter int CAL_TAP  = 1,
    localparam int SEL_W   = $clog2(NUM_TAPS)
) (
    input  logic                cal_mode,
    input  logic                alarm_en,
    input  logic                alarm_sel,
    input  logic [SEL_W-1:0]    wave_sel,
    input  logic [NUM_TAPS-1:0] freq_taps,
    input  logic                flag,
    output logic                pull_low
);

    pin_mode_e mode;

    always_comb begin
        if (cal_mode) begin
            mode = PIN_CAL;
        end else if (!alarm_sel) begin
            mode = PIN_WAVE;
        end else if (alarm_en) begin
            mode = PIN_ALARM;
        end else begin
            mode = PIN_OFF;
        end
    end

    always_comb begin
        case (mode)
            PIN_CAL:   pull_low = ~freq_taps[CAL_TAP];
            PIN_WAVE:  pull_low = ~freq_taps[wave_sel];
            PIN_ALARM: pull_low = flag;
            default:   pull_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_out.sv
module rtc_alarm_out
    import rtc_alarm_pkg::*;
#(
    parameter int NUM_TAPS = 4,
    parameter int CAL_TAP  = 1,
    localparam int SEL_W   = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic                ctrl_rd,
    input  logic [6:0]          cur_sec,
    input  logic [6:0]          cur_min,
    input  logic [5:0]          cur_hour,
    input  logic [5:0]          cur_date,
    input  logic [4:0]          cur_mon,
    input  logic [7:0]          alm_sec,
    input  logic [7:0]          alm_min,
    input  logic [7:0]          alm_hour,
    input  logic [7:0]          alm_date,
    input  logic [7:0]          alm_mon,
    input  logic                cal_mode,
    input  logic                alarm_en,
    input  logic                alarm_sel,
    input  logic [SEL_W-1:0]    wave_sel,
    input  logic [NUM_TAPS-1:0] freq_taps,
    output logic                alarm_flag,
    output logic                pin_pull_low
);

    logic [NUM_FIELDS-1:0][REG_W-1:0] alarm_regs;
    logic [NUM_FIELDS-1:0][REG_W-1:0] time_vals;
    logic                             match_all;

    assign alarm_regs = {alm_mon, alm_date, alm_hour, alm_min, alm_sec};
    assign time_vals  = {{3'b000, cur_mon}, {2'b00, cur_date}, {2'b00, cur_hour},
                         {1'b0, cur_min}, {1'b0, cur_sec}};

    rtc_alarm_match u_match (
        .alarm_regs (alarm_regs),
        .time_vals  (time_vals),
        .match_all  (match_all)
    );

    rtc_alarm_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (sec_tick & match_all),
        .clr_evt (ctrl_rd),
        .flag    (alarm_flag)
    );

    rtc_alarm_pinmux #(
        .NUM_TAPS (NUM_TAPS),
        .CAL_TAP  (CAL_TAP)
    ) u_pin (
        .cal_mode  (cal_mode),
        .alarm_en  (alarm_en),
        .alarm_sel (alarm_sel),
        .wave_sel  (wave_sel),
        .freq_taps (freq_taps),
        .flag      (alarm_flag),
        .pull_low  (pin_pull_low)
    );

endmodule

// File: rtl/rtc_alarm_out_chk.sv
module rtc_alarm_out_chk (
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic ctrl_rd,
    input logic match_all,
    input logic cal_mode,
    input logic alarm_en,
    input logic alarm_sel,
    input logic alarm_flag,
    input logic pin_pull_low
);

    a_r4_no_set_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !sec_tick) |=> !alarm_flag);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !ctrl_rd) |=> alarm_flag);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !(sec_tick && match_all)) |=> !alarm_flag);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && match_all) |=> alarm_flag);

    a_r9_alarm_on_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_mode && alarm_en && alarm_sel) |-> (pin_pull_low == alarm_flag));

    a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_mode && !alarm_en && alarm_sel) |-> !pin_pull_low);

endmodule

bind rtc_alarm_out rtc_alarm_out_chk u_chk (.*);

// File: tb/rtc_alarm_out_bench.sv
module rtc_alarm_out_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0, ctrl_rd = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0;
    logic [5:0] cur_hour = '0, cur_date = '0;
    logic [4:0] cur_mon = '0;
    logic [7:0] alm_sec = '1, alm_min = '1, alm_hour = '1, alm_date = '1, alm_mon = '1;
    logic       cal_mode = 1'b0, alarm_en = 1'b0, alarm_sel = 1'b1;
    logic [1:0] wave_sel = '0;
    logic [3:0] freq_taps = '0;
    wire        alarm_flag, pin_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mdl_flag = 0;

    always #2 clk = ~clk;

    rtc_alarm_out u_rtc_alarm_out (.*);

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic bit exp_match();
        bit m = 1;
        if (!alm_sec[7]  && (alm_sec[6:0]  != cur_sec))  m = 0;
        if (!alm_min[7]  && (alm_min[6:0]  != cur_min))  m = 0;
        if (!alm_hour[7] && (alm_hour[5:0] != cur_hour)) m = 0;
        if (!alm_date[7] && (alm_date[5:0] != cur_date)) m = 0;
        if (!alm_mon[7]  && (alm_mon[4:0]  != cur_mon))  m = 0;
        return m;
    endfunction

    function automatic bit exp_pin(input bit f);
        if (cal_mode)        return !freq_taps[1];
        else if (!alarm_sel) return !freq_taps[wave_sel];
        else if (alarm_en)   return f;
        else                 return 0;
    endfunction

    task automatic chk(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string pin_req();
        if (cal_mode)        return "R7";
        else if (!alarm_sel) return "R8";
        else if (alarm_en)   return "R9";
        else                 return "R10";
    endfunction

    // Inputs already driven after a negedge: check pin, clock, check flag
    task automatic step(input string flag_req);
        bit nxt;
        #0.5;
        chk(pin_pull_low, exp_pin(mdl_flag), pin_req());
        nxt = (sec_tick && exp_match()) ? 1'b1 : (ctrl_rd ? 1'b0 : mdl_flag);
        @(posedge clk);
        #1;
        mdl_flag = nxt;
        chk(alarm_flag, mdl_flag, flag_req);
        @(negedge clk);
    endtask

    task automatic set_now(input int s, input int mi, input int h, input int d, input int mo);
        cur_sec = to_bcd(s)[6:0]; cur_min = to_bcd(mi)[6:0];
        cur_hour = to_bcd(h)[5:0]; cur_date = to_bcd(d)[5:0]; cur_mon = to_bcd(mo)[4:0];
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(alarm_flag, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(alarm_flag, 1'b0, "R1");

        // R3: all fields disabled, tick sets flag
        set_now(17, 42, 9, 3, 11);
        sec_tick = 1; step("R3");
        sec_tick = 0; ctrl_rd = 1; step("R5");
        ctrl_rd = 0;

        // R4: full match but no tick
        alm_sec = {1'b0, cur_sec}; alm_min = {1'b0, cur_min};
        alm_hour = {2'b00, cur_hour}; alm_date = {2'b00, cur_date}; alm_mon = {3'b000, cur_mon};
        step("R4"); step("R4");
        // R2: one enabled field differs, tick does not set
        alm_min = {1'b0, to_bcd(43)[6:0]};
        sec_tick = 1; step("R2");
        // R2: mismatching field disabled -> sets
        alm_min[7] = 1'b1; step("R2");
        // R5: stays set without read
        sec_tick = 0; step("R5"); step("R5");
        // R6: set and read together
        alm_min = {1'b0, cur_min};
        sec_tick = 1; ctrl_rd = 1; step("R6");
        sec_tick = 0; step("R5");
        ctrl_rd = 0;
        // R11: junk in unused bits of hour, date and month
        alm_hour[6] = 1'b1; alm_date[6] = 1'b1; alm_mon[6:5] = 2'b11;
        sec_tick = 1; step("R11");
        sec_tick = 0;
        // R7: calibration overrides while the alarm keeps working
        cal_mode = 1; alarm_en = 1; alarm_sel = 1;
        ctrl_rd = 1; freq_taps = 4'b0010; step("R5");
        ctrl_rd = 0; freq_taps = 4'b1101; sec_tick = 1; step("R7");
        sec_tick = 0; cal_mode = 0;
        // R8: each tap, both alarm_en values
        alarm_sel = 0;
        for (int t = 0; t < 4; t++) begin
            wave_sel = 2'(t);
            freq_taps = 4'b1111 ^ (4'b1 << t); alarm_en = 0; step("R8");
            freq_taps = 4'b1 << t;             alarm_en = 1; step("R8");
        end
        // R9 / R10
        alarm_sel = 1; alarm_en = 1; step("R9");
        alarm_en = 0; step("R10");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            set_now($urandom_range(0, 59), $urandom_range(0, 59), $urandom_range(0, 23),
                    $urandom_range(1, 31), $urandom_range(1, 12));
            alm_sec  = ($urandom % 2) ? {1'b0, cur_sec} : {1'b0, to_bcd($urandom_range(0, 59))[6:0]};
            alm_min  = ($urandom % 2) ? {1'b0, cur_min} : {1'b0, to_bcd($urandom_range(0, 59))[6:0]};
            alm_hour = ($urandom % 2) ? {2'(($urandom)), cur_hour} : 8'($urandom);
            alm_date = ($urandom % 2) ? {2'(($urandom)), cur_date} : 8'($urandom);
            alm_mon  = ($urandom % 2) ? {3'(($urandom)), cur_mon} : 8'($urandom);
            alm_sec[7]  = ($urandom % 3) == 0;
            alm_min[7]  = ($urandom % 3) == 0;
            alm_hour[7] = (($urandom % 3) == 0) ? 1'b1 : 1'b0;
            alm_date[7] = ($urandom % 2) == 0;
            alm_mon[7]  = ($urandom % 2) == 0;
            sec_tick  = ($urandom % 2) == 0;
            ctrl_rd   = ($urandom % 4) == 0;
            cal_mode  = ($urandom % 5) == 0;
            alarm_en  = $urandom % 2;
            alarm_sel = ($urandom % 4) != 0;
            wave_sel  = 2'($urandom);
            freq_taps = 4'($urandom);
            step("R2");
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule